// File: doc/BRIEF.md
# Code Memory Byte-Program and Erase Sequencer

This block manages a small on-chip code memory over a parallel programming port. A programmer supplies an address, a data byte, a two-bit operation select and an active-low program strobe. One strobe pulse in program mode starts a self-timed byte write. Holding the strobe low in erase mode for a long interval wipes the whole array to FFh. Verify reads return stored bytes, and signature reads return fixed identification codes.

While a write is in flight the block reports busy. A read of the byte being written returns bit 7 inverted, so a programmer can poll for completion on the data lines alone. Two lock flags taken as inputs inhibit programming and verify readback. All timing constants are parameters counted in clock cycles. At reset the block runs an erase sweep, so the array always starts blank.

Top module: `nvm_prog_seq`

## Requirements
- R1: While reset is held, readyOut is 0, busyOut is 1 and dataOut is 00h. After release an erase sweep keeps the block busy for exactly 2^ADDR_W cycles, and then every byte reads FFh.
- R2: In program mode (modeSel 01), a low-to-high transition of strobeN seen by an idle block starts a write. readyOut drops at the next clock edge and stays low for exactly WRITE_CYC cycles. busyOut is always the inverse of readyOut.
- R3: When a write completes, the addressed byte holds the bitwise AND of its previous value and the written data. A blank byte therefore takes the new value exactly.
- R4: While a write is in flight, a verify read (modeSel 00) of its address returns the complement of the written bit 7 on bit 7 and the old stored bits 6..0. Once the write finishes, the true byte is returned.
- R5: In erase mode (modeSel 10), if an idle block samples strobeN low on ERASE_HOLD consecutive edges, an erase sweep starts. The sweep is busy for 2^ADDR_W cycles and sets every byte to FFh. A shorter hold changes nothing. Only one erase runs per low phase.
- R6: In signature mode (modeSel 11), address 030h reads 1Eh and 031h reads 51h. Address 032h reads 05h when LOW_VOLT is set and FFh otherwise.
- R7: A verify read returns 00h unless both lockLvl1 and lockLvl2 are 0.
- R8: With lockLvl1 at 1, a program strobe is accepted but busy is not asserted and the array is left unchanged.
- R9: Program strobes and erase holds that arrive while the block is busy are ignored.
- R10: dataOut is 00h in program and erase modes, for a verify read during an erase sweep, and for signature-mode addresses other than 030h to 032h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Operation: 00 verify, 01 program, 10 erase, 11 signature |
| addrIn | input | ADDR_W | Byte address |
| dataIn | input | 8 | Byte to program |
| strobeN | input | 1 | Active-low program strobe |
| lockLvl1 | input | 1 | Lock level 1 programmed: inhibits programming and verify |
| lockLvl2 | input | 1 | Lock level 2 programmed: inhibits verify |
| dataOut | output | 8 | Registered read data |
| readyOut | output | 1 | High when idle, low while a write or erase runs |
| busyOut | output | 1 | Status copy of the busy state |

## Verification
Read data is registered, so the value for an address and mode applied before a clock edge appears just after that edge. The bench drives inputs on falling edges and samples one falling edge later. The strobe rise is sampled at an edge, and readyOut falls in that same edge. It stays low for WRITE_CYC edges on a write and for 2^ADDR_W edges on an erase sweep. The bench counts those falling edges exactly. The erase trigger lands on the ERASE_HOLD-th low sample, so holds of ERASE_HOLD-1 and ERASE_HOLD cycles bracket it. A behavioural model advances on every rising edge, and its outputs are compared with the design on every falling edge.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    MODE_VERIFY    = 2'b00,
    MODE_PROGRAM   = 2'b01,
    MODE_ERASE     = 2'b10,
    MODE_SIGNATURE = 2'b11
  } opMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchWr;    // capture address and data of a new write
    logic commitWr;   // merge captured byte into the array
    logic sweepWr;    // erase the byte at the sweep pointer
    logic writeBusy;  // a byte write is in flight
    logic eraseBusy;  // an erase sweep is in flight
  } ctrlStrb_t;

  localparam int          SIG_BASE   = 'h30;
  localparam logic [7:0]  SIG_MAKER  = 8'h1E;
  localparam logic [7:0]  SIG_DEVICE = 8'h51;
  localparam logic [7:0]  SIG_HV     = 8'hFF;
  localparam logic [7:0]  SIG_LV     = 8'h05;

endpackage

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WRITE_CYC  = 375000,
  parameter int ERASE_HOLD = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  opMode_e           mode,
  input  logic              strobeN,
  input  logic              lockLvl1,
  output ctrlStrb_t         strb,
  output logic [ADDR_W-1:0] sweepAddr,
  output logic              busy
);

  localparam int WCNT_W = $clog2(WRITE_CYC + 1);
  localparam int HCNT_W = $clog2(ERASE_HOLD + 1);

  logic              strobePrevQ;
  logic              writeBusyQ;
  logic              eraseBusyQ;
  logic [WCNT_W-1:0] wrCntQ;
  logic [HCNT_W-1:0] holdCntQ;
  logic              holdDoneQ;
  logic [ADDR_W-1:0] sweepAddrQ;

  logic strobeRise;
  logic idle;
  logic progStart;
  logic holdLow;
  logic eraseStart;
  logic sweepLast;
  logic writeDone;

  assign strobeRise = strobeN & ~strobePrevQ;
  assign idle       = ~writeBusyQ & ~eraseBusyQ;
  assign progStart  = idle & strobeRise & (mode == MODE_PROGRAM) & ~lockLvl1;
  assign holdLow    = ~strobeN & (mode == MODE_ERASE);
  assign eraseStart = idle & holdLow & ~holdDoneQ
                    & (holdCntQ == HCNT_W'(ERASE_HOLD - 1));
  assign sweepLast  = eraseBusyQ & (sweepAddrQ == {ADDR_W{1'b1}});
  assign writeDone  = writeBusyQ & (wrCntQ == '0);

  always_comb begin
    strb.latchWr   = progStart;
    strb.commitWr  = writeDone;
    strb.sweepWr   = eraseBusyQ;
    strb.writeBusy = writeBusyQ;
    strb.eraseBusy = eraseBusyQ;
  end

  assign sweepAddr = sweepAddrQ;
  assign busy      = writeBusyQ | eraseBusyQ;

  // Strobe edge tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrevQ <= 1'b1;
    else       strobePrevQ <= strobeN;
  end

  // Erase sweep, also run out of reset so the array starts blank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseBusyQ <= 1'b1;
      sweepAddrQ <= '0;
    end else if (eraseBusyQ) begin
      sweepAddrQ <= sweepAddrQ + ADDR_W'(1);
      if (sweepLast) eraseBusyQ <= 1'b0;
    end else if (eraseStart) begin
      eraseBusyQ <= 1'b1;
      sweepAddrQ <= '0;
    end
  end

  // Self-timed byte write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeBusyQ <= 1'b0;
      wrCntQ     <= '0;
    end else if (writeBusyQ) begin
      if (writeDone) writeBusyQ <= 1'b0;
      else           wrCntQ     <= wrCntQ - WCNT_W'(1);
    end else if (progStart) begin
      writeBusyQ <= 1'b1;
      wrCntQ     <= WCNT_W'(WRITE_CYC - 1);
    end
  end

  // Erase hold timer, one trigger per low phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCntQ  <= '0;
      holdDoneQ <= 1'b0;
    end else if (!holdLow) begin
      holdCntQ  <= '0;
      holdDoneQ <= 1'b0;
    end else if (!idle) begin
      holdCntQ  <= '0;
    end else if (!holdDoneQ) begin
      if (eraseStart) begin
        holdCntQ  <= '0;
        holdDoneQ <= 1'b1;
      end else begin
        holdCntQ  <= holdCntQ + HCNT_W'(1);
      end
    end
  end

  AST_ONE_JOB: assert property (@(posedge clk) disable iff (!rstN) !(writeBusyQ && eraseBusyQ)); // R9
  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN) (writeBusyQ && wrCntQ != '0) |=> writeBusyQ); // R2
  AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rstN) writeDone |=> !writeBusyQ); // R2
  AST_LOCK_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN) (idle && strobeRise && mode == MODE_PROGRAM && lockLvl1) |=> !writeBusyQ); // R8
  AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rstN) sweepLast |=> !eraseBusyQ); // R5
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN) (eraseBusyQ && !sweepLast) |=> (eraseBusyQ && sweepAddrQ == $past(sweepAddrQ) + ADDR_W'(1))); // R9

endmodule

// File: rtl/nvm_prog_dp.sv
module nvm_prog_dp
  import nvm_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter bit LOW_VOLT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] sweepAddr,
  input  opMode_e           mode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic              lockLvl1,
  input  logic              lockLvl2,
  output logic [7:0]        dataOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        memArr [DEPTH];
  logic [ADDR_W-1:0] wrAddrQ;
  logic [7:0]        wrDataQ;
  logic [7:0]        rdWord;
  logic [7:0]        nextOut;
  logic [7:0]        sigVariant;
  logic              verifyOk;
  logic              pollHit;

  if (LOW_VOLT) begin : g_lowVolt
    assign sigVariant = SIG_LV;
  end else begin : g_highVolt
    assign sigVariant = SIG_HV;
  end

  // Captured write target
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrQ <= '0;
      wrDataQ <= '0;
    end else if (strb.latchWr) begin
      wrAddrQ <= addrIn;
      wrDataQ <= dataIn;
    end
  end

  // Array: one write port, shared by sweep and commit
  always_ff @(posedge clk) begin
    if (strb.sweepWr)       memArr[sweepAddr] <= 8'hFF;
    else if (strb.commitWr) memArr[wrAddrQ]   <= memArr[wrAddrQ] & wrDataQ;
  end

  assign verifyOk = ~lockLvl1 & ~lockLvl2;
  assign pollHit  = strb.writeBusy & (addrIn == wrAddrQ);

  always_comb begin
    rdWord  = memArr[addrIn];
    nextOut = '0;
    case (mode)
      MODE_VERIFY: begin
        if (!strb.eraseBusy && verifyOk) begin
          nextOut = rdWord;
          if (pollHit) nextOut[7] = ~wrDataQ[7];
        end
      end
      MODE_SIGNATURE: begin
        if (addrIn == ADDR_W'(SIG_BASE))          nextOut = SIG_MAKER;
        else if (addrIn == ADDR_W'(SIG_BASE + 1)) nextOut = SIG_DEVICE;
        else if (addrIn == ADDR_W'(SIG_BASE + 2)) nextOut = sigVariant;
      end
      default: nextOut = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOut <= '0;
    else       dataOut <= nextOut;
  end

  AST_POLL_BIT7: assert property (@(posedge clk) disable iff (!rstN) (mode == MODE_VERIFY && verifyOk && strb.writeBusy && !strb.eraseBusy && addrIn == wrAddrQ) |=> dataOut[7] != $past(wrDataQ[7])); // R4
  AST_SIG_MAKER: assert property (@(posedge clk) disable iff (!rstN) (mode == MODE_SIGNATURE && addrIn == ADDR_W'(SIG_BASE)) |=> dataOut == 8'h1E); // R6
  AST_VERIFY_GATED: assert property (@(posedge clk) disable iff (!rstN) (mode == MODE_VERIFY && (lockLvl1 || lockLvl2)) |=> dataOut == 8'h00); // R7
  AST_ERASE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN) (strb.eraseBusy && mode == MODE_VERIFY) |=> dataOut == 8'h00); // R10
  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rstN) !(strb.sweepWr && strb.commitWr)); // R9

endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
  import nvm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WRITE_CYC  = 375000,
  parameter int ERASE_HOLD = 2500000,
  parameter bit LOW_VOLT   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic              strobeN,
  input  logic              lockLvl1,
  input  logic              lockLvl2,
  output logic [7:0]        dataOut,
  output logic              readyOut,
  output logic              busyOut
);

  opMode_e           opMode;
  ctrlStrb_t         strb;
  logic [ADDR_W-1:0] sweepAddr;
  logic              busy;

  assign opMode = opMode_e'(modeSel);

  nvm_prog_ctrl #(
    .ADDR_W    (ADDR_W),
    .WRITE_CYC (WRITE_CYC),
    .ERASE_HOLD(ERASE_HOLD)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (opMode),
    .strobeN  (strobeN),
    .lockLvl1 (lockLvl1),
    .strb     (strb),
    .sweepAddr(sweepAddr),
    .busy     (busy)
  );

  nvm_prog_dp #(
    .ADDR_W  (ADDR_W),
    .LOW_VOLT(LOW_VOLT)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sweepAddr(sweepAddr),
    .mode     (opMode),
    .addrIn   (addrIn),
    .dataIn   (dataIn),
    .lockLvl1 (lockLvl1),
    .lockLvl2 (lockLvl2),
    .dataOut  (dataOut)
  );

  assign readyOut = ~busy;
  assign busyOut  = busy;

  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rstN) readyOut != busyOut); // R2

endmodule

// File: tb/test_nvm_prog_seq.sv
module test_nvm_prog_seq;

  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;
  localparam int WCYC  = 20;
  localparam int HOLD  = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeSel = 2'b00;
  logic [AW-1:0] addrIn = '0;
  logic [7:0]    dataIn = '0;
  logic          strobeN = 1'b1;
  logic          lockLvl1 = 1'b0;
  logic          lockLvl2 = 1'b0;
  logic [7:0]    dataOut;
  logic          readyOut;
  logic          busyOut;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    finished = 1'b0;

  always #2 clk = ~clk;

  nvm_prog_seq #(
    .ADDR_W    (AW),
    .WRITE_CYC (WCYC),
    .ERASE_HOLD(HOLD),
    .LOW_VOLT  (1'b0)
  ) i_nvm_prog_seq (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .strobeN (strobeN),
    .lockLvl1(lockLvl1),
    .lockLvl2(lockLvl2),
    .dataOut (dataOut),
    .readyOut(readyOut),
    .busyOut (busyOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [7:0]    refMem [DEPTH];
  bit            refWr, refEr, refPrev, refHoldDone, modelOn;
  int            refCnt, refHold, refIdx;
  logic [AW-1:0] refA;
  logic [7:0]    refD;
  logic [7:0]    expData;
  bit            expReady, expBusy;

  always @(posedge clk) begin : refModel
    logic [7:0] nxt;
    bit rise, idle, holdLow, startE;
    if (!rstN) begin
      refEr = 1; refWr = 0; refIdx = 0; refCnt = 0; refPrev = 1;
      refHold = 0; refHoldDone = 0;
      expData = 8'h00; expReady = 0; expBusy = 1;
    end else begin
      nxt = 8'h00;
      if (modeSel == 2'b00) begin
        if (!refEr && !lockLvl1 && !lockLvl2) begin
          nxt = refMem[addrIn];
          if (refWr && addrIn == refA) nxt[7] = ~refD[7];
        end
      end else if (modeSel == 2'b11) begin
        if (addrIn == 12'h030)      nxt = 8'h1E;
        else if (addrIn == 12'h031) nxt = 8'h51;
        else if (addrIn == 12'h032) nxt = 8'hFF;
      end
      rise    = strobeN && !refPrev;
      idle    = !refWr && !refEr;
      holdLow = !strobeN && modeSel == 2'b10;
      startE  = 0;
      if (!holdLow) begin
        refHold = 0; refHoldDone = 0;
      end else if (!idle) begin
        refHold = 0;
      end else if (!refHoldDone) begin
        if (refHold == HOLD - 1) begin
          startE = 1; refHold = 0; refHoldDone = 1;
        end else refHold++;
      end
      if (refEr) begin
        refMem[refIdx] = 8'hFF;
        if (refIdx == DEPTH - 1) refEr = 0; else refIdx++;
      end else if (startE) begin
        refEr = 1; refIdx = 0;
      end
      if (refWr) begin
        if (refCnt == 0) begin
          refMem[refA] = refMem[refA] & refD; refWr = 0;
        end else refCnt--;
      end else if (idle && rise && modeSel == 2'b01 && !lockLvl1) begin
        refWr = 1; refCnt = WCYC - 1; refA = addrIn; refD = dataIn;
      end
      refPrev  = strobeN;
      expData  = nxt;
      expReady = !(refWr || refEr);
      expBusy  = refWr || refEr;
    end
    modelOn = 1;
  end

  always @(negedge clk) begin
    if (modelOn && !finished) begin
      chk({curReq, " model data"},  dataOut,  expData);
      chk({curReq, " model ready"}, readyOut, expReady);
      chk({curReq, " model busy"},  busyOut,  expBusy);
    end
  end

  task automatic finishRun;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    modeSel = 2'b01; addrIn = a; dataIn = d; strobeN = 1'b0;
    @(negedge clk);
    strobeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic rdm(input logic [1:0] m, input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    modeSel = m; addrIn = a;
    @(negedge clk);
    chk(tag, dataOut, exp);
  endtask

  task automatic waitReady;
    while (!readyOut) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin : mainSeq
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", readyOut, 0);
    chk("R1 reset busy",  busyOut, 1);
    chk("R1 reset data",  dataOut, 8'h00);
    rstN = 1'b1;
    n = 0;
    while (!readyOut) begin @(negedge clk); n++; end
    chk("R1 sweep length", n, DEPTH);
    rdm(2'b00, 12'h123, 8'hFF, "R1 blank");
    rdm(2'b00, 12'hFFF, 8'hFF, "R1 blank top");

    curReq = "R2";
    prog(12'h010, 8'hA5);
    chk("R2 ready low", readyOut, 0);
    chk("R2 busy high", busyOut, 1);
    curReq = "R4";
    rdm(2'b00, 12'h010, 8'h7F, "R4 poll");
    rdm(2'b00, 12'h011, 8'hFF, "R4 other addr");
    waitReady();
    curReq = "R3";
    rdm(2'b00, 12'h010, 8'hA5, "R3 blank write");
    prog(12'h010, 8'h3C);
    waitReady();
    rdm(2'b00, 12'h010, 8'h24, "R3 and-merge");

    curReq = "R2";
    prog(12'h050, 8'h5A);
    n = 0;
    while (!readyOut) begin @(negedge clk); n++; end
    chk("R2 write length", n, WCYC);

    curReq = "R9";
    prog(12'h020, 8'h0F);
    prog(12'h021, 8'h00);
    waitReady();
    rdm(2'b00, 12'h020, 8'h0F, "R9 first write");
    rdm(2'b00, 12'h021, 8'hFF, "R9 ignored write");

    curReq = "R8";
    lockLvl1 = 1'b1;
    prog(12'h040, 8'h00);
    chk("R8 no busy", readyOut, 1);
    lockLvl1 = 1'b0;
    rdm(2'b00, 12'h040, 8'hFF, "R8 unchanged");

    curReq = "R7";
    lockLvl2 = 1'b1;
    rdm(2'b00, 12'h010, 8'h00, "R7 lock2");
    lockLvl2 = 1'b0; lockLvl1 = 1'b1;
    rdm(2'b00, 12'h010, 8'h00, "R7 lock1");
    lockLvl1 = 1'b0;
    rdm(2'b00, 12'h010, 8'h24, "R7 unlocked");

    curReq = "R6";
    rdm(2'b11, 12'h030, 8'h1E, "R6 maker");
    rdm(2'b11, 12'h031, 8'h51, "R6 device");
    rdm(2'b11, 12'h032, 8'hFF, "R6 variant");
    curReq = "R10";
    rdm(2'b11, 12'h033, 8'h00, "R10 sig other");
    rdm(2'b01, 12'h010, 8'h00, "R10 program mode");

    curReq = "R5";
    @(negedge clk);
    modeSel = 2'b10; strobeN = 1'b0;
    repeat (HOLD - 1) @(negedge clk);
    chk("R5 short hold", readyOut, 1);
    strobeN = 1'b1;
    rdm(2'b00, 12'h010, 8'h24, "R5 short hold kept");
    @(negedge clk);
    modeSel = 2'b10; strobeN = 1'b0;
    repeat (HOLD) @(negedge clk);
    chk("R5 erase busy", readyOut, 0);
    chk("R10 erase data", dataOut, 8'h00);
    repeat (DEPTH + 30) @(negedge clk);
    chk("R5 single erase", readyOut, 1);
    strobeN = 1'b1;
    rdm(2'b00, 12'h010, 8'hFF, "R5 erased");
    rdm(2'b00, 12'h020, 8'hFF, "R5 erased 2");
    curReq = "R3";
    prog(12'h010, 8'h12);
    waitReady();
    rdm(2'b00, 12'h010, 8'h12, "R3 after erase");
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule